// File: doc/BRIEF.md
# Fuse array access controller

This block sits between a 32-bit register bus and a small one-time-programmable fuse store. Public fuse words are exposed read-only through a direct window, so any word can be fetched in a single bus read. Gated words are reached only through an indirect command path. Software writes a command word that carries an unlock byte, a byte offset and a read or burn request. It then waits for the request bit to drop on its own. After that it collects the word from a result register, or, for a burn, the word has been merged into the store.

The fuse store is modelled as a register array. On reset it loads a computed pattern that stands in for factory-blown content. Burning can only turn bits on. A multi-word field such as a 16-byte key is fetched as four word accesses at consecutive 4-byte offsets.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the command register, the burn-data register and the result register all read 0. Fuse byte n holds (37*n + 0x5B) mod 256.
- R2: A read at byte address 0x200 + k, for k below 4*FUSE_WORDS, returns fuse word k/4 (the low two address bits are dropped). Fuse byte 4w+j appears in bits [8j+7:8j]. Writes into this window change nothing.
- R3: The command register is at 0x40. Bits [23:16] hold the byte offset, bits [15:8] the unlock byte, bit 1 the read request and bit 0 the burn request. It reads back as {8'h00, offset, unlock byte, 6'b0, read, burn}. A write whose unlock byte is not 0xAC is dropped whole and starts nothing.
- R4: An accepted read request copies the fuse word at offset/4 (offset aligned down) into the result register at 0x60, which is read-only.
- R5: An accepted request bit reads back as 1 for exactly LATENCY (8) cycles after the accepting write, then clears without any bus action.
- R6: An accepted burn request ORs the burn-data register (0x50) into the fuse word at offset/4. No fuse bit ever goes from 1 to 0.
- R7: While a request is in progress, writes to 0x40 and to 0x50 are ignored.
- R8: A command with both request bits set performs only the read. Only bit 1 reads back as set, and the store is left unchanged.
- R9: Each read returns data with rvalid one cycle after rd_en. Offsets that map to nothing return 0.
- R10: At most one request bit is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The assertions check several properties on every cycle. At most one request bit is set at a time. A request never stays busy longer than the latency, and it always ends exactly at it. Dropped and in-progress command writes leave the offset untouched. A burn never clears a bit. A finished read lands the selected word in the result register. Unmapped reads return zero one cycle later. The bench scenarios are what show the data itself. They cover the reset fuse pattern and its byte order, alignment of odd offsets, the exact cycle at which the request bit drops, the effect of a burn as seen through the window, and the read-over-burn priority when both bits are set.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'hAC;
  localparam int CTRL_OFS = 'h40;
  localparam int PKEY_OFS = 'h50;
  localparam int RKEY_OFS = 'h60;
  localparam int WIN_BASE = 'h200;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_READ = 2'd1,
    CMD_PROG = 2'd2
  } cmd_e;

  // factory pattern for one fuse byte
  function automatic logic [7:0] seed_byte(input int n);
    int v;
    v = (n * 37 + 91) % 256;
    return v[7:0];
  endfunction

  // little-endian packing of four seed bytes
  function automatic logic [31:0] seed_word(input int w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = seed_byte(4 * w + b);
    return r;
  endfunction

  function automatic logic key_ok(input logic [31:0] d);
    return d[15:8] == UNLOCK_KEY;
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic [7:0] off, input logic [7:0] key,
                                            input logic rd, input logic wr);
    return {8'h00, off, key, 6'b0, rd, wr};
  endfunction

  // fuse burning can only set bits
  function automatic logic [31:0] burn(input logic [31:0] old, input logic [31:0] data);
    return old | data;
  endfunction
endpackage

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burn_en,
  input  logic [IDX_W-1:0] burn_idx,
  input  logic [31:0]      burn_data,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic [31:0]      win_word,
  output logic [31:0]      cmd_word
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= seed_word(i);
    end else if (burn_en) begin
      mem[burn_idx] <= burn(mem[burn_idx], burn_data);
    end
  end

  assign win_word = mem[win_idx];
  assign cmd_word = mem[cmd_idx];
endmodule

// File: rtl/fuse_cmd_fsm.sv
module fuse_cmd_fsm
  import fuse_pkg::*;
#(
  parameter int LATENCY = 8,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             pkey_we,
  input  logic [31:0]      wdata,
  input  logic [31:0]      cmd_word,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      pkey_rd,
  output logic [31:0]      rdkey_rd,
  output logic             busy,
  output logic             rd_busy,
  output logic             wr_busy,
  output logic             fin_read,
  output logic             fin_prog,
  output logic [7:0]       cmd_off,
  output logic [IDX_W-1:0] cmd_idx
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  cmd_e             state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       off_q, key_q;
  logic [31:0]      pkey_q, rdkey_q;
  logic             accept, last;

  assign busy     = state != CMD_IDLE;
  assign rd_busy  = state == CMD_READ;
  assign wr_busy  = state == CMD_PROG;
  assign last     = busy && (cnt == '0);
  assign fin_read = last && rd_busy;
  assign fin_prog = last && wr_busy;
  assign accept   = ctrl_we && !busy && key_ok(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CMD_IDLE;
      cnt     <= '0;
      off_q   <= '0;
      key_q   <= '0;
      pkey_q  <= '0;
      rdkey_q <= '0;
    end else begin
      if (accept) begin
        off_q <= wdata[23:16];
        key_q <= wdata[15:8];
        if (wdata[1]) begin
          state <= CMD_READ;
          cnt   <= CNT_W'(LATENCY - 1);
        end else if (wdata[0]) begin
          state <= CMD_PROG;
          cnt   <= CNT_W'(LATENCY - 1);
        end
      end else if (last) begin
        state <= CMD_IDLE;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (fin_read) rdkey_q <= cmd_word;
      if (pkey_we && !busy) pkey_q <= wdata;
    end
  end

  assign cmd_off  = off_q;
  assign cmd_idx  = IDX_W'(off_q[7:2]);
  assign ctrl_rd  = pack_ctrl(off_q, key_q, rd_busy, wr_busy);
  assign pkey_rd  = pkey_q;
  assign rdkey_rd = rdkey_q;
endmodule

// File: rtl/fuse_regif.sv
module fuse_regif
  import fuse_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       ctrl_rd,
  input  logic [31:0]       pkey_rd,
  input  logic [31:0]       rdkey_rd,
  input  logic [31:0]       win_word,
  output logic              ctrl_we,
  output logic              pkey_we,
  output logic [IDX_W-1:0]  win_idx,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_LEN = ADDR_W'(4 * WORDS);

  logic [ADDR_W-1:0] aligned, win_rel;
  logic hit_ctrl, hit_pkey, hit_rkey, hit_win;
  logic [31:0] rd_mux;

  assign aligned  = {addr[ADDR_W-1:2], 2'b00};
  assign hit_ctrl = aligned == ADDR_W'(CTRL_OFS);
  assign hit_pkey = aligned == ADDR_W'(PKEY_OFS);
  assign hit_rkey = aligned == ADDR_W'(RKEY_OFS);
  assign win_rel  = addr - WIN_LO;
  assign hit_win  = (addr >= WIN_LO) && (win_rel < WIN_LEN);
  assign win_idx  = win_rel[IDX_W+1:2];

  assign ctrl_we = wr_en && hit_ctrl;
  assign pkey_we = wr_en && hit_pkey;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = ctrl_rd;
    else if (hit_pkey) rd_mux = pkey_rd;
    else if (hit_rkey) rd_mux = rdkey_rd;
    else if (hit_win)  rd_mux = win_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FUSE_WORDS = 64,
  parameter int LATENCY    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  localparam int IDX_W = $clog2(FUSE_WORDS);

  logic             ctrl_we, pkey_we;
  logic [31:0]      ctrl_rd, pkey_rd, rdkey;
  logic [31:0]      win_word, cmd_word;
  logic [IDX_W-1:0] win_idx, cmd_idx;
  logic             busy, rd_busy, wr_busy, fin_read, fin_prog;
  logic [7:0]       cmd_off;

  fuse_regif #(.ADDR_W(ADDR_W), .WORDS(FUSE_WORDS), .IDX_W(IDX_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .ctrl_rd(ctrl_rd), .pkey_rd(pkey_rd), .rdkey_rd(rdkey), .win_word(win_word),
    .ctrl_we(ctrl_we), .pkey_we(pkey_we), .win_idx(win_idx),
    .rdata(rdata), .rvalid(rvalid)
  );

  fuse_cmd_fsm #(.LATENCY(LATENCY), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .pkey_we(pkey_we), .wdata(wdata),
    .cmd_word(cmd_word), .ctrl_rd(ctrl_rd), .pkey_rd(pkey_rd), .rdkey_rd(rdkey),
    .busy(busy), .rd_busy(rd_busy), .wr_busy(wr_busy), .fin_read(fin_read),
    .fin_prog(fin_prog), .cmd_off(cmd_off), .cmd_idx(cmd_idx)
  );

  fuse_store #(.WORDS(FUSE_WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .burn_en(fin_prog), .burn_idx(cmd_idx),
    .burn_data(pkey_rd), .win_idx(win_idx), .cmd_idx(cmd_idx),
    .win_word(win_word), .cmd_word(cmd_word)
  );
endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk
  import fuse_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FUSE_WORDS = 64,
  parameter int LATENCY    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              rvalid,
  input logic              busy,
  input logic              rd_busy,
  input logic              wr_busy,
  input logic              fin_read,
  input logic              fin_prog,
  input logic [7:0]        cmd_off,
  input logic [31:0]       cmd_word,
  input logic [31:0]       rdkey
);
  localparam int LEN_W = $clog2(LATENCY + 2);

  logic [LEN_W-1:0] busy_len;
  logic unmapped, ctrl_wr;
  int unsigned a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  always_comb begin
    a = 32'(addr);
    unmapped = !(((a & ~32'd3) == CTRL_OFS) || ((a & ~32'd3) == PKEY_OFS) ||
                 ((a & ~32'd3) == RKEY_OFS) ||
                 (a >= WIN_BASE && a < WIN_BASE + 4 * FUSE_WORDS));
    ctrl_wr = wr_en && ((a & ~32'd3) == CTRL_OFS);
  end

  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rd_busy, wr_busy}));
  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> busy_len < LEN_W'(LATENCY));
  // R5
  busy_exact_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> busy_len == LEN_W'(LATENCY));
  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && wdata[15:8] != UNLOCK_KEY) |=> (!busy && $stable(cmd_off)));
  // R7
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> $stable(cmd_off));
  // R6
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_prog |=> ((cmd_word & $past(cmd_word)) == $past(cmd_word)));
  // R4
  rd_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_read |=> (rdkey == $past(cmd_word)));
  // R9
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rvalid);
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata == 32'h0));
endmodule

bind fuse_ctl fuse_ctl_chk #(.ADDR_W(ADDR_W), .FUSE_WORDS(FUSE_WORDS), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .rvalid(rvalid), .busy(busy), .rd_busy(rd_busy), .wr_busy(wr_busy),
  .fin_read(fin_read), .fin_prog(fin_prog), .cmd_off(cmd_off), .cmd_word(cmd_word),
  .rdkey(rdkey)
);

// File: tb/fuse_ctl_test.sv
`timescale 1ns/1ps
module fuse_ctl_test;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [7:0] mb [256];

  always #2.5 clk = ~clk;

  fuse_ctl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  function automatic logic [31:0] mword(input int w);
    return {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]};
  endfunction

  task automatic mburn(input int w, input logic [31:0] d);
    for (int j = 0; j < 4; j++) mb[4*w+j] = mb[4*w+j] | d[8*j +: 8];
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares every returned read against the scoreboard
  always @(negedge clk) begin
    if (rvalid) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected read data %h expected none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    logic [7:0] v;
    v = 8'h5B;
    for (int n = 0; n < 256; n++) begin
      mb[n] = v;
      v = v + 8'd37;
    end

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    bus_read(12'h040, 32'h0, "R1 ctrl");
    bus_read(12'h050, 32'h0, "R1 burn data");
    bus_read(12'h060, 32'h0, "R1 result");

    // R2 root key words and window edges
    for (int w = 0; w < 4; w++) bus_read(12'h200 + 12'(4*w), mword(w), "R2 key word");
    bus_read(12'h2FC, mword(63), "R2 last word");
    bus_read(12'h213, mword(4), "R2 unaligned");

    // R9 unmapped offsets
    bus_read(12'h000, 32'h0, "R9 zero");
    bus_read(12'h044, 32'h0, "R9 0x44");
    bus_read(12'h05C, 32'h0, "R9 0x5C");
    bus_read(12'h300, 32'h0, "R9 past window");

    // R2 window write ignored
    bus_write(12'h204, 32'hFFFF_FFFF);
    bus_read(12'h204, mword(1), "R2 window write");

    // R4 R5 indirect read with exact latency
    bus_write(12'h040, 32'h0034_AC02);
    bus_read(12'h040, 32'h0034_AC02, "R5 busy first");
    idle(LAT - 2);
    bus_read(12'h040, 32'h0034_AC02, "R5 busy last");
    bus_read(12'h040, 32'h0034_AC00, "R5 cleared");
    bus_read(12'h060, mword(13), "R4 result");

    // R3 wrong unlock byte
    bus_write(12'h040, 32'h0010_AB02);
    bus_read(12'h040, 32'h0034_AC00, "R3 bad key ctrl");
    idle(LAT + 2);
    bus_read(12'h060, mword(13), "R3 bad key result");

    // R6 R7 burn with writes during busy
    bus_write(12'h050, 32'h8000_0101);
    bus_read(12'h050, 32'h8000_0101, "R6 burn data");
    bus_write(12'h040, 32'h000B_AC01);
    bus_read(12'h040, 32'h000B_AC01, "R5 burn busy");
    bus_write(12'h040, 32'h0020_AC02);
    bus_write(12'h050, 32'h1234_5678);
    idle(LAT);
    mburn(2, 32'h8000_0101);
    bus_read(12'h040, 32'h000B_AC00, "R7 ctrl kept");
    bus_read(12'h050, 32'h8000_0101, "R7 burn data kept");
    bus_read(12'h208, mword(2), "R6 burned word");

    // R6 second burn keeps old bits
    bus_write(12'h050, 32'h0000_00F0);
    bus_write(12'h040, 32'h0008_AC01);
    idle(LAT + 1);
    mburn(2, 32'h0000_00F0);
    bus_read(12'h208, mword(2), "R6 second burn");

    // R8 both bits: read only
    bus_write(12'h040, 32'h0000_AC03);
    bus_read(12'h040, 32'h0000_AC02, "R8 ctrl");
    idle(LAT + 1);
    bus_read(12'h060, mword(0), "R8 result");
    bus_read(12'h200, mword(0), "R8 no burn");

    // R4 indirect read of burned word, odd offset
    bus_write(12'h040, 32'h0009_AC02);
    idle(LAT + 1);
    bus_read(12'h060, mword(2), "R4 burned readback");

    idle(3);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9 missing %0d reads actual 0 expected %0d", sb.size(), sb.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule